// File: doc/BRIEF.md
# Class-Sorted Interrupt Packet Queues with Two-Level Cause

This block takes interrupt packets that arrive with a two-bit class tag and files each one into one of four circular queues, one queue per class. A packet goes to the tail of its class queue, and the queue's write pointer is kept inside the block. Each queue offers its oldest entry to a consumer. The consumer drains the queue with a one-cycle pop strobe and so moves the read pointer toward the write pointer.

The block has two cause registers. The local cause register holds one pending bit per queue, and that bit is high whenever its queue holds data. On the next clock each local bit is copied into the external half of a processor-level cause register. The internal half of that register is set by a separate request port and cleared by the consumer through a write-one-to-clear port. Any set bit in the processor-level register raises a single exception request.

A packet sent to a full queue is thrown away, and the queue's sticky overflow flag is set.

Top module: `irq_pktq`

## Requirements
- R1: The class code selects the queue: 0 for interprocessor communication, 1 for I/O, 2 for errors from either of those, 3 for coherency. A stored packet goes to the tail of its queue. Lane k of `head_data` (bits k*DW upward) shows the oldest entry of queue k. Entries leave in arrival order, and the pointers wrap around the DEPTH slots.
- R2: `head_valid[k]` is high while queue k holds at least one entry. A `pop[k]` pulse on a non-empty queue removes the head. A pop on an empty queue is ignored.
- R3: A packet for a full queue (DEPTH entries) is dropped and sets `ovf[k]`, which stays set until reset. This holds even when the same queue is popped in that cycle.
- R4: A push and a pop on the same queue in the same cycle, when the queue is neither empty nor full, both take effect.
- R5: `local_cause[k]` rises on the clock edge that stores the first packet in queue k. It clears on the edge at which queue k becomes empty.
- R6: Bit DW-independent index NINT+k of `cpu_cause` follows `local_cause[k]` one clock later, both when it sets and when it clears.
- R7: A high `int_set[i]` sets `cpu_cause[i]` on the next edge. Repeating the request while the bit is pending changes nothing.
- R8: A high `int_clr[i]` clears `cpu_cause[i]` on the next edge. When set and clear arrive together, the bit stays set.
- R9: `exc_req` is high exactly when at least one `cpu_cause` bit is set.
- R10: Asserting reset (asynchronous, active low) empties every queue and clears both cause registers, the overflow flags and `exc_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Incoming packet strobe |
| pkt_class | input | 2 | Target queue of the packet |
| pkt_data | input | DW | Packet payload |
| int_set | input | NINT | Internal cause set requests |
| int_clr | input | NINT | Internal cause write-one-to-clear |
| pop | input | 4 | Per-queue pop strobe |
| head_data | output | 4*DW | Oldest entry of each queue, one lane per queue |
| head_valid | output | 4 | Per-queue non-empty flag |
| ovf | output | 4 | Sticky per-queue overflow flag |
| local_cause | output | 4 | Local cause register |
| cpu_cause | output | NINT+4 | Processor cause: internal bits low, queue bits high |
| exc_req | output | 1 | Exception request |

## Verification
The bench builds the block with DEPTH=4, DW=16 and NINT=4, instead of the defaults of 16 slots of 64 bits. With four slots, a queue fills after a handful of pushes. That brings several cases within a short run: the dropped fifth packet, the sticky overflow flag, a push and pop on a full queue, and pointer wrap-around after the queue drains and refills. The one-cycle lag between a local bit and its external cause bit is checked on both the rising and the falling side, and the set-wins collision is checked on the internal bits.

// File: rtl/irq_pktq.sv
module irq_pktq #(
  parameter int DEPTH = 16,
  parameter int DW    = 64,
  parameter int NINT  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_valid,
  input  logic [1:0]          pkt_class,
  input  logic [DW-1:0]       pkt_data,
  input  logic [NINT-1:0]     int_set,
  input  logic [NINT-1:0]     int_clr,
  input  logic [3:0]          pop,
  output logic [4*DW-1:0]     head_data,
  output logic [3:0]          head_valid,
  output logic [3:0]          ovf,
  output logic [3:0]          local_cause,
  output logic [NINT+3:0]     cpu_cause,
  output logic                exc_req
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLN = (AW+1)'(DEPTH);

  logic [NINT-1:0] icause;
  logic [3:0]      xcause;

  for (genvar q = 0; q < 4; q++) begin : g_q
    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wp, rp;
    logic [AW:0]   fill;
    logic          push, full, take;

    assign fill = wp - rp;
    assign full = (fill == FULLN);
    assign push = pkt_valid && (pkt_class == 2'(q));
    assign take = pop[q] && (wp != rp);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp     <= '0;
        rp     <= '0;
        ovf[q] <= 1'b0;
      end else begin
        if (push && !full) wp <= wp + 1'b1;
        if (push && full)  ovf[q] <= 1'b1;
        if (take)          rp <= rp + 1'b1;
      end
    end

    always_ff @(posedge clk)
      if (push && !full) mem[wp[AW-1:0]] <= pkt_data;

    assign head_valid[q]          = (wp != rp);
    assign local_cause[q]         = head_valid[q];
    assign head_data[q*DW +: DW]  = mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icause <= '0;
      xcause <= '0;
    end else begin
      icause <= (icause & ~int_clr) | int_set;
      xcause <= local_cause;
    end
  end

  assign cpu_cause = {xcause, icause};
  assign exc_req   = |cpu_cause;
endmodule

// File: rtl/irq_pktq_chk.sv
module irq_pktq_chk #(
  parameter int NINT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pkt_valid,
  input logic [1:0]      pkt_class,
  input logic [NINT-1:0] int_set,
  input logic [NINT-1:0] int_clr,
  input logic [3:0]      pop,
  input logic [3:0]      head_valid,
  input logic [3:0]      local_cause,
  input logic [3:0]      ovf,
  input logic [NINT+3:0] cpu_cause,
  input logic            exc_req
);
  p_int_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cpu_cause[NINT-1:0] & $past(int_set)) == $past(int_set)));

  p_int_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cpu_cause[NINT-1:0] & $past(int_clr & ~int_set)) == '0));

  p_ext_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_cause[NINT +: 4] == $past(local_cause)));

  p_exc_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_req) |-> $past((int_set != '0) || (local_cause != '0)));

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |-> (!exc_req && ovf == '0 && head_valid == '0));

  for (genvar k = 0; k < 4; k++) begin : g_k
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[k] |=> ovf[k]);

    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[k]) |-> $past(pkt_valid && pkt_class == 2'(k) && head_valid[k]));

    p_pop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!head_valid[k] && !(pkt_valid && pkt_class == 2'(k))) |=> !head_valid[k]);

    p_local_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid[k] && !pop[k]) |=> local_cause[k]);
  end
endmodule

bind irq_pktq irq_pktq_chk #(.NINT(NINT)) u_chk (.*);

// File: tb/sim_irq_pktq.sv
module sim_irq_pktq;
  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int NINT  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pv = 1'b0;
  logic [1:0]      cls = '0;
  logic [DW-1:0]   dat = '0;
  logic [NINT-1:0] iset = '0, iclr = '0;
  logic [3:0]      pops = '0;
  logic [4*DW-1:0] hd;
  logic [3:0]      hv, ovf, lc;
  logic [NINT+3:0] cc;
  logic            exc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_pktq #(.DEPTH(DEPTH), .DW(DW), .NINT(NINT)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pv), .pkt_class(cls), .pkt_data(dat),
    .int_set(iset), .int_clr(iclr), .pop(pops), .head_data(hd),
    .head_valid(hv), .ovf(ovf), .local_cause(lc), .cpu_cause(cc), .exc_req(exc));

  // [30] push, [29:28] class, [27:12] data, [11:8] pop, [7:4] head_valid, [3:0] ovf
  localparam logic [30:0] VEC [8] = '{
    {1'b1, 2'd0, 16'hA001, 4'b0000, 4'b0001, 4'b0000},
    {1'b1, 2'd2, 16'hA002, 4'b0000, 4'b0101, 4'b0000},
    {1'b0, 2'd0, 16'h0000, 4'b0001, 4'b0100, 4'b0000},
    {1'b0, 2'd0, 16'h0000, 4'b0010, 4'b0100, 4'b0000},
    {1'b1, 2'd3, 16'hA003, 4'b0000, 4'b1100, 4'b0000},
    {1'b0, 2'd0, 16'h0000, 4'b0100, 4'b1000, 4'b0000},
    {1'b1, 2'd1, 16'hA004, 4'b1000, 4'b0010, 4'b0000},
    {1'b0, 2'd0, 16'h0000, 4'b0010, 4'b0000, 4'b0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    pv = 1'b0; cls = '0; dat = '0; pops = '0; iset = '0; iclr = '0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [1:0] c, input logic [DW-1:0] d);
    pv = 1'b1; cls = c; dat = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    chk("R10 reset head_valid", 64'(hv), 64'h0);
    chk("R10 reset exc", 64'(exc), 64'h0);
    chk("R10 reset cause", 64'(cc), 64'h0);
    rst_n = 1'b1;
    cyc();

    for (int i = 0; i < 8; i++) begin
      pv = VEC[i][30]; cls = VEC[i][29:28]; dat = VEC[i][27:12]; pops = VEC[i][11:8];
      cyc();
      chk("R1/R2 table head_valid", 64'(hv), 64'(VEC[i][7:4]));
      chk("R3 table ovf", 64'(ovf), 64'(VEC[i][3:0]));
      idle();
    end
    cyc();

    // R5 R6 R9 cause chain
    push(2'd2, 16'h0B0B); cyc(); idle();
    chk("R5 local set", 64'(lc), 64'h4);
    chk("R6 ext lag", 64'(cc), 64'h0);
    chk("R9 no exc yet", 64'(exc), 64'h0);
    cyc();
    chk("R6 ext set", 64'(cc), 64'h40);
    chk("R9 exc raised", 64'(exc), 64'h1);
    pops = 4'b0100; cyc(); idle();
    chk("R5 local clear", 64'(lc), 64'h0);
    chk("R6 ext clear lag", 64'(cc), 64'h40);
    cyc();
    chk("R6 ext cleared", 64'(cc), 64'h0);
    chk("R9 exc dropped", 64'(exc), 64'h0);

    // R7 R8 internal bits
    iset = 4'b0010; cyc(); idle();
    chk("R7 int set", 64'(cc), 64'h2);
    chk("R9 exc internal", 64'(exc), 64'h1);
    iset = 4'b0010; cyc(); idle();
    chk("R7 repeat set", 64'(cc), 64'h2);
    iset = 4'b0010; iclr = 4'b0110; cyc(); idle();
    chk("R8 set wins", 64'(cc), 64'h2);
    iclr = 4'b0010; cyc(); idle();
    chk("R8 cleared", 64'(cc), 64'h0);
    chk("R9 exc off", 64'(exc), 64'h0);

    // R1 R3 fill, overflow, order, wrap
    for (int i = 0; i < DEPTH; i++) begin
      push(2'd1, 16'(16'h10 + i)); cyc();
    end
    idle();
    chk("R3 full no ovf", 64'(ovf), 64'h0);
    push(2'd1, 16'h14); cyc(); idle();
    chk("R3 ovf set", 64'(ovf), 64'h2);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R1 order", 64'(hd[1*DW +: DW]), 64'(16'h10 + i));
      pops = 4'b0010; cyc(); idle();
    end
    chk("R3 dropped packet absent", 64'(hv[1]), 64'h0);
    pops = 4'b0010; cyc(); idle();
    chk("R2 pop empty ignored", 64'(hv[1]), 64'h0);
    push(2'd1, 16'h20); cyc(); push(2'd1, 16'h21); cyc(); idle();
    chk("R1 wrap head", 64'(hd[1*DW +: DW]), 64'h20);
    chk("R3 ovf sticky", 64'(ovf), 64'h2);
    pops = 4'b0010; cyc(); idle();
    chk("R1 wrap second", 64'(hd[1*DW +: DW]), 64'h21);
    pops = 4'b0010; cyc(); idle();

    // R4 and full push+pop
    push(2'd0, 16'h30); cyc();
    push(2'd0, 16'h31); pops = 4'b0001; cyc(); idle();
    chk("R4 push+pop head", 64'(hd[0 +: DW]), 64'h31);
    chk("R4 push+pop valid", 64'(hv[0]), 64'h1);
    for (int i = 0; i < 3; i++) begin
      push(2'd0, 16'(16'h32 + i)); cyc();
    end
    push(2'd0, 16'h35); pops = 4'b0001; cyc(); idle();
    chk("R3 full push+pop ovf", 64'(ovf), 64'h3);
    chk("R3 full push+pop head", 64'(hd[0 +: DW]), 64'h32);
    for (int i = 0; i < 3; i++) begin
      chk("R3 no dropped entry", 64'(hd[0 +: DW]), 64'(16'h32 + i));
      pops = 4'b0001; cyc(); idle();
    end
    chk("R2 drained", 64'(hv[0]), 64'h0);

    // R10 reset mid-run
    iset = 4'b1000; push(2'd3, 16'h44); cyc(); idle();
    rst_n = 1'b0; #1;
    chk("R10 async hv", 64'(hv), 64'h0);
    chk("R10 async ovf", 64'(ovf), 64'h0);
    chk("R10 async cause", 64'(cc), 64'h0);
    chk("R10 async exc", 64'(exc), 64'h0);
    @(negedge clk); rst_n = 1'b1; cyc();
    chk("R10 after release", 64'(lc), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule